// File: doc/BRIEF.md
# Serial TDM Time-Slot Interchange Switch

This block moves eight-bit voice channels between serial time-division streams. Two serial inputs and two serial outputs each carry 32 channels per frame at one bit per clock. The bits of each channel are sent most significant bit first. A frame-sync pulse marks the first bit of channel 0. Each output channel is filled from any input stream and channel, so the switch never blocks. The source is chosen by a connection-memory entry. That entry also holds a flag that turns the output channel off.

Incoming bytes go into a data memory with two banks per stream. The banks swap roles at every frame boundary. In constant-delay mode every connection is delayed by exactly one frame. In variable-delay mode a byte is sent in the same frame when its source slot has already fully arrived, and in the following frame otherwise. A global enable can switch every output driver off. A small write/read port sets up and reads back the connection memory.

Top module: `tsi_switch`

## Requirements
- R1: After reset, every connection-memory entry reads back as 0x40 (off flag set, source stream 0, source channel 0), and both output enables are low.
- R2: The cycle in which `frame_sync` is high is bit position 0 of a frame. Channel c occupies the 8 cycles starting at position 8c. On inputs and outputs, the first of these 8 cycles carries the most significant bit.
- R3: A write with `cfg_wr` high stores `cfg_wdata` at `cfg_addr`, and the entry reads back on `cfg_rdata` in the next cycle. Address bit 5 selects the output stream and bits 4:0 select the output channel. Data bit 6 is the off flag, bit 5 is the source stream and bits 4:0 are the source channel.
- R4: Any output channel can take any input stream and channel. One source may feed many outputs at the same time.
- R5: With `delay_const` high, the byte that arrives in source slot s of frame k is sent in the selected output channel of frame k+1, for every pair of source and destination channels.
- R6: With `delay_const` low, a source channel numbered below the output channel is sent in the same frame. A source channel equal to or above the output channel is sent one frame later.
- R7: While `glob_oe` is low, both `ser_oe` bits are low and both `ser_out` bits are 0, whatever the connection memory holds.
- R8: While an entry's off flag is set, the matching output channel has `ser_oe` low and `ser_out` 0. Other channels are not affected.
- R9: While `glob_oe` is high and the entry's off flag is clear, `ser_oe` is high for all 8 bits of that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | High during bit position 0 of a frame |
| delay_const | input | 1 | 1 = constant one-frame delay, 0 = variable delay |
| glob_oe | input | 1 | Global enable for the output drivers |
| ser_in | input | 2 | Serial input streams |
| ser_out | output | 2 | Serial output data, 0 while its driver is off |
| ser_oe | output | 2 | Output driver enable per stream (0 = high impedance) |
| cfg_wr | input | 1 | Connection-memory write strobe |
| cfg_addr | input | 6 | Entry address {output stream, output channel} |
| cfg_wdata | input | 7 | Entry data {off flag, source stream, source channel} |
| cfg_rdata | output | 7 | Entry stored at `cfg_addr` |

## Verification
The input byte is a function of frame number, stream and channel. A byte sent one frame late therefore cannot pass for one sent on time, and a wrong source slot cannot match either. A crossed mapping (stream swapped, channel reversed) is run in both delay modes. It covers source channels below and above every destination, and so it separates the two delay rules and catches bit-order or bank mistakes. A broadcast of one slot to all 64 outputs, with alternate channels turned off, checks fan-out, the equal-channel case of variable delay and per-channel driver control. A final run with the global enable low checks that every driver is off.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  parameter int unsigned NSTR = 2;   // serial streams in and out
  parameter int unsigned NCH  = 32;  // channels per frame
  parameter int unsigned BW   = 8;   // bits per channel

  localparam int unsigned STW  = (NSTR > 1) ? $clog2(NSTR) : 1;
  localparam int unsigned CHW  = $clog2(NCH);
  localparam int unsigned BTW  = $clog2(BW);
  localparam int unsigned POSW = CHW + BTW;
  localparam int unsigned ADRW = STW + CHW;
  localparam int unsigned ENTW = 1 + STW + CHW;

  typedef struct packed {
    logic           off;
    logic [STW-1:0] st;
    logic [CHW-1:0] ch;
  } conn_ent_t;
endpackage

// File: rtl/tsi_timing.sv
module tsi_timing
  import tsi_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_sync,
  output logic [POSW-1:0] cur_pos,
  output logic            cur_par
);
  logic [POSW-1:0] pos_q, pos_nxt;
  logic            par_q, par_nxt;

  always_comb begin
    pos_nxt = frame_sync ? '0 : pos_q + 1'b1;
    par_nxt = (pos_nxt == '0) ? ~par_q : par_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '1;
      par_q <= 1'b0;
    end else begin
      pos_q <= pos_nxt;
      par_q <= par_nxt;
    end
  end

  assign cur_pos = pos_nxt;
  assign cur_par = par_nxt;

  AST_SYNC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> (pos_q == '0)); // R2
  AST_BANK_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q == '0) |-> (par_q != $past(par_q))); // R5
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem
  import tsi_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSTR-1:0] ser_in,
  input  logic [POSW-1:0] cur_pos,
  input  logic            cur_par,
  input  logic [STW-1:0]  rd_st   [NSTR],
  input  logic [CHW-1:0]  rd_ch   [NSTR],
  input  logic            rd_bank [NSTR],
  output logic [BW-1:0]   rd_byte [NSTR]
);
  logic [BW-1:0] sh_q   [NSTR];
  logic [BW-1:0] sh_nxt [NSTR];
  logic [BW-1:0] mem    [NSTR][2][NCH];
  logic          wr_en;
  logic [CHW-1:0] wr_ch;

  assign wr_en = (cur_pos[BTW-1:0] == '1);
  assign wr_ch = cur_pos[POSW-1:BTW];

  always_comb begin
    for (int s = 0; s < int'(NSTR); s++) begin
      sh_nxt[s] = {sh_q[s][BW-2:0], ser_in[s]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(NSTR); s++) sh_q[s] <= '0;
    end else begin
      for (int s = 0; s < int'(NSTR); s++) sh_q[s] <= sh_nxt[s];
    end
  end

  // Data storage carries no reset: contents are only read after a full frame.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int s = 0; s < int'(NSTR); s++) mem[s][cur_par][wr_ch] <= sh_nxt[s];
    end
  end

  genvar o;
  generate
    for (o = 0; o < int'(NSTR); o++) begin : g_rd
      assign rd_byte[o] = mem[rd_st[o]][rd_bank[o]][rd_ch[o]];
    end
  endgenerate
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem
  import tsi_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [ADRW-1:0] cfg_addr,
  input  logic [ENTW-1:0] cfg_wdata,
  output logic [ENTW-1:0] cfg_rdata,
  input  logic [CHW-1:0]  cur_ch,
  output conn_ent_t       ent [NSTR]
);
  localparam int unsigned NENT = NSTR * NCH;
  localparam conn_ent_t   RST_ENT = '{off: 1'b1, st: '0, ch: '0};

  logic [ENTW-1:0] cm_q [NENT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(NENT); i++) cm_q[i] <= RST_ENT;
    end else if (cfg_wr) begin
      cm_q[cfg_addr] <= cfg_wdata;
    end
  end

  assign cfg_rdata = cm_q[cfg_addr];

  genvar o;
  generate
    for (o = 0; o < int'(NSTR); o++) begin : g_ent
      assign ent[o] = conn_ent_t'(cm_q[{STW'(o), cur_ch}]);
    end
  endgenerate

  AST_CFG_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> ((cfg_addr != $past(cfg_addr)) || (cfg_rdata == $past(cfg_wdata)))); // R3
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_sync,
  input  logic            delay_const,
  input  logic            glob_oe,
  input  logic [NSTR-1:0] ser_in,
  output logic [NSTR-1:0] ser_out,
  output logic [NSTR-1:0] ser_oe,
  input  logic            cfg_wr,
  input  logic [ADRW-1:0] cfg_addr,
  input  logic [ENTW-1:0] cfg_wdata,
  output logic [ENTW-1:0] cfg_rdata
);
  logic [1:0]      rst_sync_q;
  logic            rst_i_n;
  logic [POSW-1:0] cur_pos;
  logic            cur_par;
  logic [CHW-1:0]  cur_ch;
  logic [BTW-1:0]  bit_sel;
  conn_ent_t       ent     [NSTR];
  logic [STW-1:0]  rd_st   [NSTR];
  logic [CHW-1:0]  rd_ch   [NSTR];
  logic            rd_bank [NSTR];
  logic [BW-1:0]   rd_byte [NSTR];

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  tsi_timing u_timing (
    .clk(clk), .rst_n(rst_i_n), .frame_sync(frame_sync),
    .cur_pos(cur_pos), .cur_par(cur_par)
  );

  assign cur_ch  = cur_pos[POSW-1:BTW];
  assign bit_sel = BTW'(BW - 1) - cur_pos[BTW-1:0];

  tsi_conn_mem u_conn (
    .clk(clk), .rst_n(rst_i_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cur_ch(cur_ch), .ent(ent)
  );

  tsi_data_mem u_data (
    .clk(clk), .rst_n(rst_i_n), .ser_in(ser_in), .cur_pos(cur_pos),
    .cur_par(cur_par), .rd_st(rd_st), .rd_ch(rd_ch), .rd_bank(rd_bank),
    .rd_byte(rd_byte)
  );

  genvar o;
  generate
    for (o = 0; o < int'(NSTR); o++) begin : g_out
      logic drv_en;
      assign rd_st[o]   = ent[o].st;
      assign rd_ch[o]   = ent[o].ch;
      // current-frame bank only when the source slot is already complete
      assign rd_bank[o] = (!delay_const && (ent[o].ch < cur_ch)) ? cur_par : ~cur_par;
      assign drv_en     = glob_oe & ~ent[o].off;
      assign ser_oe[o]  = drv_en;
      assign ser_out[o] = drv_en & rd_byte[o][bit_sel];

      AST_CH_OFF: assert property (@(posedge clk) disable iff (!rst_i_n)
        ent[o].off |-> !ser_oe[o]); // R8
      AST_QUIET_LINE: assert property (@(posedge clk) disable iff (!rst_i_n)
        !ser_oe[o] |-> !ser_out[o]); // R7
    end
  endgenerate

  AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_i_n)
    !glob_oe |-> (ser_oe == '0)); // R7
endmodule

// File: tb/tsi_switch_test.sv
module tsi_switch_test;
  import tsi_pkg::*;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            frame_sync = 1'b0;
  logic            delay_const = 1'b1;
  logic            glob_oe = 1'b1;
  logic [NSTR-1:0] ser_in = '0;
  logic [NSTR-1:0] ser_out, ser_oe;
  logic            cfg_wr = 1'b0;
  logic [ADRW-1:0] cfg_addr = '0;
  logic [ENTW-1:0] cfg_wdata = '0;
  logic [ENTW-1:0] cfg_rdata;

  int checks = 0;
  int failures = 0;
  int fk = 0;
  bit go = 0;
  bit chk_en = 0;
  bit m_const = 1;
  bit m_goe = 1;
  bit       m_off [NSTR][NCH];
  int       m_st  [NSTR][NCH];
  int       m_ch  [NSTR][NCH];

  typedef struct {
    bit       chk;
    bit       en;
    logic [7:0] data;
    string    req;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  tsi_switch uut (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .delay_const(delay_const),
    .glob_oe(glob_oe), .ser_in(ser_in), .ser_out(ser_out), .ser_oe(ser_oe),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  function automatic logic [7:0] pat(int k, int s, int ch);
    return 8'((k * 37 + s * 101 + ch * 7 + 3) & 255);
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // driver side of the scoreboard: expectations for one output frame
  task automatic push_frame(int k);
    for (int c = 0; c < int'(NCH); c++) begin
      for (int o = 0; o < int'(NSTR); o++) begin
        exp_t it;
        int sf;
        it.chk = chk_en;
        it.en  = m_goe && !m_off[o][c];
        sf = (m_const || m_ch[o][c] >= c) ? k - 1 : k;
        it.data = it.en ? pat(sf, m_st[o][c], m_ch[o][c]) : 8'h00;
        if (!m_goe)          it.req = "R7";
        else if (m_off[o][c]) it.req = "R8";
        else if (m_const)     it.req = "R2 R4 R5 R9";
        else                  it.req = "R2 R4 R6 R9";
        q.push_back(it);
      end
    end
  endtask

  // frame generator and monitor
  initial begin
    logic [7:0] acc   [NSTR];
    logic [7:0] oeacc [NSTR];
    wait (go);
    forever begin
      for (int p = 0; p < int'(NCH * BW); p++) begin
        @(negedge clk);
        frame_sync = (p == 0);
        for (int s = 0; s < int'(NSTR); s++) ser_in[s] = pat(fk, s, p / 8)[7 - (p % 8)];
        if (p == 0) push_frame(fk);
        #1;
        for (int o = 0; o < int'(NSTR); o++) begin
          acc[o]   = {acc[o][6:0], ser_out[o]};
          oeacc[o] = {oeacc[o][6:0], ser_oe[o]};
        end
        if ((p % 8) == 7) begin
          for (int o = 0; o < int'(NSTR); o++) begin
            exp_t it;
            it = q.pop_front();
            if (it.chk) begin
              checks++;
              if (acc[o] !== it.data || oeacc[o] !== (it.en ? 8'hFF : 8'h00)) begin
                failures++;
                $display("FAIL %s frame %0d out %0d ch %0d: data=%02h oe=%02h expected data=%02h oe=%02h",
                         it.req, fk, o, p / 8, acc[o], oeacc[o], it.data, it.en ? 8'hFF : 8'h00);
              end
            end
          end
        end
      end
      fk++;
    end
  end

  task automatic cfg_write(int addr, logic [ENTW-1:0] data);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = ADRW'(addr); cfg_wdata = data;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // map 0: crossed streams, reversed channels; map 1: broadcast of stream 0 ch 5
  task automatic apply(int map, bit cmode, bit goe);
    int t;
    chk_en = 0;
    t = fk;
    wait (fk == t + 1);
    for (int o = 0; o < int'(NSTR); o++) begin
      for (int c = 0; c < int'(NCH); c++) begin
        if (map == 0) begin
          m_st[o][c] = 1 - o; m_ch[o][c] = 31 - c; m_off[o][c] = 0;
        end else begin
          m_st[o][c] = 0; m_ch[o][c] = 5; m_off[o][c] = (o == 1) && (c % 2 == 1);
        end
        cfg_write(o * 32 + c, {m_off[o][c], 1'(m_st[o][c]), 5'(m_ch[o][c])});
      end
    end
    @(negedge clk);
    for (int a = 0; a < int'(NSTR * NCH); a++) begin
      logic [ENTW-1:0] e;
      cfg_addr = ADRW'(a);
      e = {m_off[a / 32][a % 32], 1'(m_st[a / 32][a % 32]), 5'(m_ch[a / 32][a % 32])};
      #1;
      checks++;
      if (cfg_rdata !== e) begin
        failures++;
        $display("FAIL R3 addr %0d: read=%02h expected=%02h", a, cfg_rdata, e);
      end
    end
    @(negedge clk);
    delay_const = cmode; m_const = cmode;
    glob_oe = goe;       m_goe = goe;
    chk_en = 1;
    wait (fk == t + 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset contents and drivers off
    for (int a = 0; a < int'(NSTR * NCH); a++) begin
      cfg_addr = ADRW'(a);
      #1;
      checks++;
      if (cfg_rdata !== 7'h40) begin
        failures++;
        $display("FAIL R1 addr %0d: read=%02h expected=40", a, cfg_rdata);
      end
      @(negedge clk);
    end
    checks++;
    if (ser_oe !== 2'b00) begin
      failures++;
      $display("FAIL R1 ser_oe=%b expected=00", ser_oe);
    end
    go = 1;
    apply(0, 1'b1, 1'b1);  // R5
    apply(0, 1'b0, 1'b1);  // R6
    apply(1, 1'b0, 1'b1);  // R4 R6 R8
    apply(1, 1'b1, 1'b0);  // R7
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end
endmodule